// File: doc/BRIEF.md
# Staggered Multi-Output Clock Divider

This block derives a family of divided clocks from one fast, free-running source clock. Four general-purpose outputs each divide the source by their own programmable amount and can be switched on and off one by one. Their rising edges are spread over consecutive source cycles, so no two of them switch in the same cycle. An internal core clock is also divided by a programmable amount, but it has no enable and keeps running. An egress data clock takes its divide ratio from a 2-bit strap. A small front-end selector, driven by a second 2-bit strap, chooses the reference for the upstream synthesizer. That reference is either a dedicated reference pin or a prescaled copy of an ingress clock.

Every divided output comes from the same three-state machine. ST_OFF holds the output low. ST_HIGH and ST_LOW each last one half period. The machine moves between states on four named transitions:

- **launch** (ST_OFF to ST_HIGH): taken once the output is enabled and the shared slot counter has reached the output's index.
- **fall** (ST_HIGH to ST_LOW): taken when the half-period count has run out.
- **rise** (ST_LOW to ST_HIGH): taken when the half-period count has run out. A new divisor is picked up here.
- **park** (ST_HIGH or ST_LOW to ST_OFF): taken on a cleared enable or on software reset.

The control register holds the half-period fields and the enables. A write port loads it, and hardware reset or software reset restores it.

Top module: `stagger_clkgen`

## Requirements
- R1: Each general output k (k = 0..3) has a 4-bit half-period field H in control register bits [4k+3:4k]. Its period is 2*H source cycles, and a field of 0 counts as 1. The four fields act independently.
- R2: Every divided output has a 50% duty cycle. The high phase and the low phase that follows it each last H source cycles.
- R3: After hardware or software reset is released, general output k makes its first rising edge exactly k source cycles after output 0.
- R4: The enable for general output k is control bit 20+k. Once a write clears it, that output goes low within two source cycles and stays low.
- R5: An output leaving ST_OFF rises only in a cycle where the shared slot counter equals its index. The slot counter counts source cycles modulo 16 and reads 0 in the first cycle after reset is released.
- R6: While hardware reset or software reset is active, all four general outputs are low.
- R7: Hardware reset and software reset both restore the control register to 24'hF22222. In that value every half field is 2, giving a period of 4, and all four enables are set.
- R8: The core clock divides by twice the half field in bits [19:16]. It has no enable and keeps toggling while software reset is active.
- R9: The egress strap selects the egress clock as the source divided by 2, 4, 6 or 8 for codes 00, 01, 10 and 11.
- R10: The reference strap passes the dedicated reference input for code 00. For codes 01, 10 and 11 it passes the ingress clock divided by 16, 8 and 4.
- R11: A change to a half-period field takes effect at that output's next rising edge. The high phase and low phase already under way finish at the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast free-running source clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset, active high |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 24 | Control register write data |
| egr_sel | input | 2 | Egress divide strap |
| ref_sel | input | 2 | Reference select strap |
| ref_in | input | 1 | Dedicated reference input |
| ingress_clk | input | 1 | Ingress clock used for the prescaled reference |
| gp_clk | output | 4 | General-purpose divided clocks |
| core_clk | output | 1 | Always-on core clock |
| egr_clk | output | 1 | Egress data clock |
| ref_out | output | 1 | Selected synthesizer reference |

## Verification
A divisor write can land in the same source cycle in which the output's half-period count runs out. In that cycle the fall or rise transition and the register update happen together. The bench provokes this by rewriting all half fields with random values at random offsets relative to the running phases. It judges the result by requiring every measured period to be an even multiple with equal high and low halves, and by checking the directed case in which the old period must finish before the new one starts. A second collision, re-enabling an output in the cycle its slot comes round, is judged from the observed slot of the first rising edge.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    // Phase states of one divided clock
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } div_state_e;

endpackage

// File: rtl/clkgen_ctl_reg.sv
module clkgen_ctl_reg #(
    parameter int              REG_W     = 24,
    parameter logic [REG_W-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_clr,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (sync_clr) begin
            q <= RESET_VAL;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/clkgen_slot_ctr.sv
module clkgen_slot_ctr #(
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    output logic [SLOT_W-1:0] slot
);

    // Shared stagger reference, zero in the first cycle after reset release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (sync_clr) begin
            slot <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end

endmodule

// File: rtl/clkgen_phase_fsm.sv
module clkgen_phase_fsm
    import clkgen_pkg::*;
#(
    parameter int HW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_clr,
    input  logic          en,
    input  logic          start_ok,
    input  logic [HW-1:0] half_in,
    output logic          clk_out
);

    div_state_e    state_q;
    div_state_e    state_nx;
    logic [HW-1:0] cnt_q;
    logic [HW-1:0] h_act_q;
    logic [HW-1:0] h_last;
    logic [HW-1:0] half_eff;
    logic          phase_done;
    logic          stay_on;

    assign half_eff   = (half_in == '0) ? HW'(1) : half_in;
    assign h_last     = h_act_q - 1'b1;
    assign phase_done = (cnt_q == h_last);
    assign stay_on    = en && !sync_clr;

    // Next-state decision: launch, fall, rise, park
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (stay_on && start_ok) state_nx = ST_HIGH;
            end
            ST_HIGH: begin
                if (!stay_on)        state_nx = ST_OFF;
                else if (phase_done) state_nx = ST_LOW;
            end
            ST_LOW: begin
                if (!stay_on)        state_nx = ST_OFF;
                else if (phase_done) state_nx = ST_HIGH;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // State register with phase counter and active half period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            h_act_q <= HW'(1);
        end else begin
            state_q <= state_nx;
            if (state_nx == ST_OFF || state_nx != state_q) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_nx == ST_HIGH && state_q != ST_HIGH) begin
                h_act_q <= half_eff;
            end
        end
    end

    // Registered output, glitch-free
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_out <= 1'b0;
        end else begin
            clk_out <= (state_nx == ST_HIGH);
        end
    end

    // R4 R6
    property disable_low_p;
        @(posedge clk) disable iff (!rst_n)
        (!en || sync_clr) |=> !clk_out;
    endproperty
    disable_low_chk: assert property (disable_low_p);

    // R5
    property start_slot_p;
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !start_ok) |=> !clk_out;
    endproperty
    start_slot_chk: assert property (start_slot_p);

    // R11
    property hold_div_p;
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW) |-> $stable(h_act_q);
    endproperty
    hold_div_chk: assert property (hold_div_p);

    // R2
    property cnt_range_p;
        @(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF) |-> (cnt_q < h_act_q);
    endproperty
    cnt_range_chk: assert property (cnt_range_p);

endmodule

// File: rtl/clkgen_ref_prescale.sv
module clkgen_ref_prescale (
    input  logic       ingress_clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       ref_in,
    output logic       ref_out
);

    logic [3:0] pre_q;

    always_ff @(posedge ingress_clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_comb begin
        unique case (sel)
            2'b00:   ref_out = ref_in;
            2'b01:   ref_out = pre_q[3];
            2'b10:   ref_out = pre_q[2];
            default: ref_out = pre_q[1];
        endcase
    end

endmodule

// File: rtl/stagger_clkgen.sv
module stagger_clkgen #(
    parameter int N_GP      = 4,
    parameter int HW        = 4,
    parameter int SLOT_W    = 4,
    parameter int INIT_HALF = 2,
    localparam int REG_W    = (N_GP + 1) * HW + N_GP
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] ctl_wdata,
    input  logic [1:0]       egr_sel,
    input  logic [1:0]       ref_sel,
    input  logic             ref_in,
    input  logic             ingress_clk,
    output logic [N_GP-1:0]  gp_clk,
    output logic             core_clk,
    output logic             egr_clk,
    output logic             ref_out
);

    localparam int CORE_LSB = N_GP * HW;
    localparam int EN_LSB   = (N_GP + 1) * HW;

    function automatic logic [REG_W-1:0] init_ctl();
        logic [REG_W-1:0] v;
        v = '0;
        for (int i = 0; i <= N_GP; i++) begin
            v[i*HW +: HW] = HW'(INIT_HALF);
        end
        for (int i = 0; i < N_GP; i++) begin
            v[EN_LSB + i] = 1'b1;
        end
        return v;
    endfunction

    localparam logic [REG_W-1:0] CTL_INIT = init_ctl();

    logic [REG_W-1:0]  ctl_q;
    logic [SLOT_W-1:0] slot;
    logic [HW-1:0]     egr_half;

    clkgen_ctl_reg #(.REG_W(REG_W), .RESET_VAL(CTL_INIT)) u_ctl (
        .clk(clk_src), .rst_n(rst_n), .sync_clr(soft_rst),
        .we(ctl_we), .wdata(ctl_wdata), .q(ctl_q)
    );

    clkgen_slot_ctr #(.SLOT_W(SLOT_W)) u_slot (
        .clk(clk_src), .rst_n(rst_n), .sync_clr(soft_rst), .slot(slot)
    );

    for (genvar k = 0; k < N_GP; k++) begin : g_gp
        clkgen_phase_fsm #(.HW(HW)) u_div (
            .clk(clk_src), .rst_n(rst_n), .sync_clr(soft_rst),
            .en(ctl_q[EN_LSB + k]),
            .start_ok(slot == SLOT_W'(k)),
            .half_in(ctl_q[k*HW +: HW]),
            .clk_out(gp_clk[k])
        );
    end

    clkgen_phase_fsm #(.HW(HW)) u_core (
        .clk(clk_src), .rst_n(rst_n), .sync_clr(1'b0), .en(1'b1),
        .start_ok(1'b1), .half_in(ctl_q[CORE_LSB +: HW]), .clk_out(core_clk)
    );

    assign egr_half = HW'(egr_sel) + HW'(1);

    clkgen_phase_fsm #(.HW(HW)) u_egr (
        .clk(clk_src), .rst_n(rst_n), .sync_clr(1'b0), .en(1'b1),
        .start_ok(1'b1), .half_in(egr_half), .clk_out(egr_clk)
    );

    clkgen_ref_prescale u_ref (
        .ingress_clk(ingress_clk), .rst_n(rst_n), .sel(ref_sel),
        .ref_in(ref_in), .ref_out(ref_out)
    );

    // R6
    property softrst_low_p;
        @(posedge clk_src) disable iff (!rst_n)
        soft_rst |=> (gp_clk == '0);
    endproperty
    softrst_low_chk: assert property (softrst_low_p);

endmodule

// File: tb/stagger_clkgen_tb_top.sv
module stagger_clkgen_tb_top;

    localparam int NO = 6;
    localparam logic [23:0] INIT = 24'hF22222;

    logic        clk_src = 1'b0, ingress_clk = 1'b0;
    logic        rst_n = 1'b0, soft_rst = 1'b0, ctl_we = 1'b0, ref_in = 1'b0;
    logic [23:0] ctl_wdata = '0, shadow = INIT;
    logic [1:0]  egr_sel = 2'b00, ref_sel = 2'b00;
    logic [3:0]  gp_clk;
    logic        core_clk, egr_clk, ref_out;
    logic [5:0]  outs;

    always #4 clk_src = ~clk_src;
    always #3 ingress_clk = ~ingress_clk;

    stagger_clkgen dut_i (
        .clk_src(clk_src), .rst_n(rst_n), .soft_rst(soft_rst), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .egr_sel(egr_sel), .ref_sel(ref_sel), .ref_in(ref_in),
        .ingress_clk(ingress_clk), .gp_clk(gp_clk), .core_clk(core_clk),
        .egr_clk(egr_clk), .ref_out(ref_out)
    );

    assign outs = {egr_clk, core_clk, gp_clk};

    int n_chk = 0, n_fail = 0;
    int cyc = 0, ref_cyc = 0;
    logic [5:0] prev = '0;
    int  last_rise[NO], last_fall[NO], per_m[NO], hi_m[NO], rise_n[NO], first_rise[NO], duty_err[NO];
    bit  have_rise[NO], have_fall[NO], first_seen[NO];
    bit  trk_clr = 1'b1;
    int  ri_last = 0, ri_per = 0, ri_cyc = 0;
    logic ri_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eh(input logic [3:0] h);
        return (h == 4'd0) ? 1 : int'(h);
    endfunction

    // Edge monitor, sampled away from the active edge
    always @(negedge clk_src) begin
        cyc++;
        for (int i = 0; i < NO; i++) begin
            if (outs[i] && !prev[i]) rise_n[i]++;
            if (trk_clr) begin
                have_rise[i] = 0; have_fall[i] = 0; first_seen[i] = 0;
                duty_err[i] = 0; per_m[i] = 0; hi_m[i] = 0;
            end else begin
                if (outs[i] && !prev[i]) begin
                    if (have_rise[i]) per_m[i] = cyc - last_rise[i];
                    if (have_rise[i] && have_fall[i] && (cyc - last_fall[i]) != hi_m[i])
                        duty_err[i]++;
                    last_rise[i] = cyc; have_rise[i] = 1;
                    if (!first_seen[i]) begin first_seen[i] = 1; first_rise[i] = cyc; end
                end
                if (!outs[i] && prev[i]) begin
                    if (have_rise[i]) hi_m[i] = cyc - last_rise[i];
                    last_fall[i] = cyc; have_fall[i] = 1;
                end
            end
            prev[i] = outs[i];
        end
    end

    always @(negedge ingress_clk) begin
        ri_cyc++;
        if (ref_out && !ri_prev) begin
            ri_per  = ri_cyc - ri_last;
            ri_last = ri_cyc;
        end
        ri_prev = ref_out;
    end

    task automatic wr(input logic [23:0] v);
        @(posedge clk_src); #1;
        ctl_we = 1'b1; ctl_wdata = v;
        @(posedge clk_src); #1;
        ctl_we = 1'b0;
    endtask

    task automatic check_stagger(input string tag);
        repeat (40) @(negedge clk_src);
        for (int k = 0; k < 4; k++) begin
            chk(first_seen[k] && (first_rise[k] - first_rise[0]) == k, "R3 stagger",
                first_rise[k] - first_rise[0], k);
            chk(per_m[k] == 4 && hi_m[k] == 2, {"R7 initial period ", tag}, per_m[k], 4);
        end
        ref_cyc = first_rise[0];
    endtask

    initial begin
        int bad;
        int base;
        int r;
        logic [3:0] h[5];
        void'($urandom(32'd20240517));

        // Hard reset: all divided outputs low
        repeat (5) @(negedge clk_src);
        chk(outs == 6'b0, "R6 hard reset low", int'(outs), 0);
        @(posedge clk_src); #1;
        rst_n = 1'b1; trk_clr = 1'b0;
        check_stagger("after hard reset");
        chk(per_m[4] == 4, "R8 core initial period", per_m[4], 4);

        // Random and directed divisors
        for (int it = 0; it < 7; it++) begin
            for (int i = 0; i < 5; i++) h[i] = 4'($urandom_range(0, 15));
            if (it == 0) begin h[0] = 4'd0; h[1] = 4'd15; h[2] = 4'd1; h[3] = 4'd7; h[4] = 4'd3; end
            shadow = {4'hF, h[4], h[3], h[2], h[1], h[0]};
            repeat ($urandom_range(0, 9)) @(negedge clk_src);
            wr(shadow);
            repeat (110) @(negedge clk_src);
            for (int i = 0; i < 4; i++) begin
                chk(per_m[i] == 2 * eh(h[i]), "R1 period", per_m[i], 2 * eh(h[i]));
                chk(hi_m[i] == eh(h[i]), "R2 high phase", hi_m[i], eh(h[i]));
            end
            chk(per_m[4] == 2 * eh(h[4]), "R8 core period", per_m[4], 2 * eh(h[4]));
        end
        for (int i = 0; i < 5; i++) chk(duty_err[i] == 0, "R2 duty across changes", duty_err[i], 0);

        // Divisor change lands mid high phase
        shadow[3:0] = 4'd6;
        wr(shadow);
        repeat (40) @(negedge clk_src);
        r = rise_n[0];
        wait (rise_n[0] != r);
        shadow[3:0] = 4'd2;
        wr(shadow);
        r = rise_n[0];
        wait (rise_n[0] != r);
        chk(per_m[0] == 12 && hi_m[0] == 6, "R11 old period completes", per_m[0], 12);
        r = rise_n[0];
        wait (rise_n[0] != r);
        chk(per_m[0] == 4, "R11 new period at next rise", per_m[0], 4);

        // Disable then re-enable each general output
        for (int k = 0; k < 4; k++) begin
            shadow[20 + k] = 1'b0;
            wr(shadow);
            repeat (2) @(negedge clk_src);
            bad = 0;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk_src);
                if (gp_clk[k]) bad++;
            end
            chk(bad == 0, "R4 disabled output low", bad, 0);
            repeat ($urandom_range(0, 15)) @(negedge clk_src);
            @(posedge clk_src); #1;
            trk_clr = 1'b1;
            shadow[20 + k] = 1'b1;
            wr(shadow);
            trk_clr = 1'b0;
            repeat (40) @(negedge clk_src);
            chk(first_seen[k] && ((first_rise[k] - ref_cyc) % 16) == k, "R5 relaunch slot",
                (first_rise[k] - ref_cyc) % 16, k);
        end

        // Software reset
        @(posedge clk_src); #1;
        soft_rst = 1'b1; trk_clr = 1'b1;
        base = rise_n[4];
        @(negedge clk_src);
        bad = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk_src);
            if (gp_clk != 4'b0) bad++;
        end
        chk(bad == 0, "R6 soft reset low", bad, 0);
        chk(rise_n[4] - base >= 8, "R8 core runs in soft reset", rise_n[4] - base, 10);
        @(posedge clk_src); #1;
        soft_rst = 1'b0; trk_clr = 1'b0; shadow = INIT;
        check_stagger("after soft reset");

        // Egress strap
        for (int c = 0; c < 4; c++) begin
            @(posedge clk_src); #1;
            egr_sel = 2'(c);
            repeat (30) @(negedge clk_src);
            chk(per_m[5] == 2 * (c + 1) && hi_m[5] == c + 1, "R9 egress divide", per_m[5], 2 * (c + 1));
        end

        // Reference select
        ref_sel = 2'b00;
        for (int c = 0; c < 8; c++) begin
            #2 ref_in = 1'($urandom_range(0, 1));
            #1 chk(ref_out == ref_in, "R10 direct reference", int'(ref_out), int'(ref_in));
        end
        for (int c = 1; c < 4; c++) begin
            ref_sel = 2'(c);
            repeat (60) @(negedge ingress_clk);
            chk(ri_per == (32 >> c), "R10 prescaled reference", ri_per, 32 >> c);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule